// File: doc/BRIEF.md
# Parallel LCD bus master sequencer

This block sits on the host side of a 128x64 graphic display built from two 64-column controller halves that share an 8-bit, E-strobed bus with separate read/write and register-select lines. A client hands it one command at a time through a valid/ready handshake: an instruction write, a display data write or a display data read, each aimed at the left or right half. The sequencer turns each command into one or more complete bus cycles. It derives every phase length from minimum nanosecond limits divided by the system clock period and rounded up, so no setup, hold, width or period limit falls short at any clock rate.

Before every transfer the sequencer reads the addressed half's status byte, and keeps polling while that half reports busy or still in reset. A display data read is always carried out as a throw-away read followed by the real read, each preceded by a poll, and only the second value is returned. If a half stays busy for too long, the command is dropped and a one-cycle error pulse is raised.

Top module: `lcd_bus_seq`

## Requirements
- R1: While rst_ni is low and after its release, lcd_e_o, lcd_db_oe_o, lcd_cs1_o, lcd_cs2_o, rsp_valid_o and err_o are 0 and cmd_ready_o is 1.
- R2: A bus cycle to half 0 (cmd_half_i = 0) drives lcd_cs1_o = 1, lcd_cs2_o = 0; to half 1 it drives lcd_cs1_o = 0, lcd_cs2_o = 1; while E is high exactly one select is set.
- R3: With the default 4 ns clock, E stays high at least 113 cycles (450 ns and the 320 ns read access plus one cycle), low at least 113 cycles, and successive E rises are at least 250 cycles (1000 ns) apart.
- R4: lcd_cs1_o, lcd_cs2_o, lcd_rs_o and lcd_rw_o are stable at least 35 cycles (140 ns) before E rises and at least 3 cycles (10 ns) after E falls.
- R5: On writes the data bus is driven (lcd_db_oe_o = 1) with stable data at least 50 cycles (200 ns) before E falls and at least 3 cycles after it.
- R6: On any cycle with lcd_rw_o = 1 the output enable is off before E rises and stays off while E is high; read data is taken on the clock edge where E falls.
- R7: Every transfer is preceded by a status read (lcd_rs_o = 0, lcd_rw_o = 1) to the same half returning bit 7 (busy) = 0 and bit 4 (in reset) = 0; polling repeats while either bit is 1.
- R8: A data read (cmd_op_i = 2 or 3) performs two data-read bus cycles; the first value is discarded and the second is returned on rsp_data_o.
- R9: If 256 consecutive status reads report busy or reset, the next busy status ends the command: err_o pulses for one cycle, no transfer takes place, and the sequencer returns to idle.
- R10: cmd_ready_o is 1 only when idle and a command is taken on cmd_valid_i and cmd_ready_o both high; rsp_valid_o pulses for one cycle only for data reads. Encoding: cmd_op_i 0 = instruction write (RS 0, RW 0), 1 = data write (RS 1, RW 0), 2 or 3 = data read (RS 1, RW 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted this cycle if valid |
| cmd_op_i | input | 2 | Operation: 0 instruction write, 1 data write, 2/3 data read |
| cmd_half_i | input | 1 | Target half: 0 left, 1 right |
| cmd_data_i | input | 8 | Byte to write |
| rsp_valid_o | output | 1 | One-cycle pulse with read result |
| rsp_data_o | output | 8 | Byte returned by a data read |
| err_o | output | 1 | One-cycle pulse on poll timeout |
| lcd_cs1_o | output | 1 | Left half select |
| lcd_cs2_o | output | 1 | Right half select |
| lcd_rs_o | output | 1 | Register select: 0 instruction/status, 1 data |
| lcd_rw_o | output | 1 | 1 read, 0 write |
| lcd_e_o | output | 1 | Enable strobe |
| lcd_db_o | output | 8 | Data bus output value |
| lcd_db_oe_o | output | 1 | Data bus output enable |
| lcd_db_i | input | 8 | Data bus input value |

## Verification
The bench places a two-half display model on the bus that reports reset for a few status reads after power-up and busy after each write, and that presents junk on the bus until 320 ns into E high, so a design sampling read data too early or skipping a poll returns wrong bytes or trips the model's poll check. It measures every phase against its cycle minimum, so a phase counter short by one cycle is reported at the first access. Reads after an explicit column set check that the throw-away read is issued, since a design without it returns the byte latched by the previous access. A half held busy for 300 polls must yield exactly 257 status reads, one error pulse and no write, catching an off-by-one limit or a dropped abort.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam logic [1:0] OP_INSTR = 2'd0;
  localparam logic [1:0] OP_WDATA = 2'd1;
  localparam logic [1:0] OP_RDATA = 2'd2;

  localparam int unsigned STAT_BUSY_BIT = 7;
  localparam int unsigned STAT_RST_BIT  = 4;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_bus_cycle.sv
module lcd_bus_cycle
  import lcd_seq_pkg::*;
#(
  parameter int N_ASU = 35,
  parameter int N_EH  = 113,
  parameter int N_AH  = 3,
  parameter int N_GAP = 99
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       half_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] wdata_i,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       cs1_o,
  output logic       cs2_o,
  output logic       rs_o,
  output logic       rw_o,
  output logic       e_o,
  output logic [7:0] db_o,
  output logic       db_oe_o,
  input  logic [7:0] db_i
);

  localparam int N_MAX = imax(imax(N_ASU, N_EH), imax(N_AH, N_GAP));
  localparam int CNT_W = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD, PH_GAP} phase_e;

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
      cs1_o   <= 1'b0;
      cs2_o   <= 1'b0;
      rs_o    <= 1'b0;
      rw_o    <= 1'b0;
      e_o     <= 1'b0;
      db_o    <= '0;
      db_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          cs1_o   <= ~half_i;
          cs2_o   <= half_i;
          rs_o    <= rs_i;
          rw_o    <= rw_i;
          db_o    <= rw_i ? 8'h00 : wdata_i;
          db_oe_o <= ~rw_i;
          cnt_q   <= CNT_W'(N_ASU - 1);
          phase_q <= PH_SETUP;
        end
        PH_SETUP: if (cnt_zero) begin
          e_o     <= 1'b1;
          cnt_q   <= CNT_W'(N_EH - 1);
          phase_q <= PH_HIGH;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HIGH: if (cnt_zero) begin
          e_o     <= 1'b0;
          if (rw_o) rdata_o <= db_i;
          cnt_q   <= CNT_W'(N_AH - 1);
          phase_q <= PH_HOLD;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_zero) begin
          cs1_o   <= 1'b0;
          cs2_o   <= 1'b0;
          db_oe_o <= 1'b0;
          cnt_q   <= CNT_W'(N_GAP - 1);
          phase_q <= PH_GAP;
        end else cnt_q <= cnt_q - 1'b1;
        PH_GAP: if (cnt_zero) begin
          done_o  <= 1'b1;
          phase_q <= PH_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // independent E-high length tracker for the width check
  logic [CNT_W:0] ehi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ehi_len_q <= '0;
    else if (!e_o)                ehi_len_q <= '0;
    else if (~&ehi_len_q)         ehi_len_q <= ehi_len_q + 1'b1;
  end

  assert_e_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(e_o) |-> (ehi_len_q >= (CNT_W+1)'(N_EH)));

  assert_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_o && $past(e_o)) |-> $stable({cs1_o, cs2_o, rs_o, rw_o}));

  assert_sel_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_o |-> (cs1_o ^ cs2_o));

  assert_wdata_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_oe_o && $past(db_oe_o)) |-> $stable(db_o));

  assert_oe_off_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_o && (cs1_o || cs2_o)) |-> !db_oe_o);

endmodule

// File: rtl/lcd_poll_guard.sv
module lcd_poll_guard #(
  parameter int LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic expire_o
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == CNT_W'(LIMIT));

  assert_guard_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !step_i);

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_half_i,
  input  logic [7:0] cmd_data_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       err_o,
  output logic       bus_start_o,
  output logic       bus_half_o,
  output logic       bus_rs_o,
  output logic       bus_rw_o,
  output logic [7:0] bus_wdata_o,
  input  logic       bus_done_i,
  input  logic [7:0] bus_rdata_i,
  output logic       guard_clear_o,
  output logic       guard_step_o,
  input  logic       guard_expire_i
);

  typedef enum logic [2:0] {ST_IDLE, ST_POLL_GO, ST_POLL_WAIT, ST_XFER_GO, ST_XFER_WAIT} state_e;

  state_e     state_q;
  logic [1:0] op_q;
  logic       half_q;
  logic [7:0] data_q;
  logic       dummy_q;
  logic       poll_ok_q;
  logic       accept;
  logic       stat_busy;
  logic       poll_end;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign stat_busy   = bus_rdata_i[STAT_BUSY_BIT] | bus_rdata_i[STAT_RST_BIT];
  assign poll_end    = (state_q == ST_POLL_WAIT) && bus_done_i;

  assign bus_start_o = (state_q == ST_POLL_GO) || (state_q == ST_XFER_GO);
  assign bus_half_o  = half_q;
  assign bus_rs_o    = (state_q == ST_XFER_GO) && (op_q != OP_INSTR);
  assign bus_rw_o    = (state_q == ST_XFER_GO) ? op_q[1] : 1'b1;
  assign bus_wdata_o = data_q;

  assign guard_step_o  = poll_end && stat_busy && !guard_expire_i;
  assign guard_clear_o = accept || (poll_end && !stat_busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_INSTR;
      half_q      <= 1'b0;
      data_q      <= '0;
      dummy_q     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= cmd_op_i;
          half_q  <= cmd_half_i;
          data_q  <= cmd_data_i;
          dummy_q <= cmd_op_i[1];
          state_q <= ST_POLL_GO;
        end
        ST_POLL_GO: state_q <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (bus_done_i) begin
          if (!stat_busy)          state_q <= ST_XFER_GO;
          else if (guard_expire_i) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else                 state_q <= ST_POLL_GO;
        end
        ST_XFER_GO: state_q <= ST_XFER_WAIT;
        ST_XFER_WAIT: if (bus_done_i) begin
          if (op_q[1] && dummy_q) begin
            dummy_q <= 1'b0;
            state_q <= ST_POLL_GO;
          end else begin
            if (op_q[1]) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= bus_rdata_i;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // a ready status must have been seen since the last bus access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        poll_ok_q <= 1'b0;
    else if (poll_end && !stat_busy)    poll_ok_q <= 1'b1;
    else if (bus_start_o)               poll_ok_q <= 1'b0;
  end

  assert_poll_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER_GO) |-> poll_ok_q);

  assert_ready_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  assert_rsp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!err_o && cmd_ready_o));

endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
  import lcd_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_CYCLE_NS    = 1000,
  parameter int T_EH_NS       = 450,
  parameter int T_EL_NS       = 450,
  parameter int T_ASU_NS      = 140,
  parameter int T_AH_NS       = 10,
  parameter int T_DSU_NS      = 200,
  parameter int T_DH_NS       = 10,
  parameter int T_RDV_NS      = 320,
  parameter int POLL_LIMIT    = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_half_i,
  input  logic [7:0] cmd_data_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       err_o,
  output logic       lcd_cs1_o,
  output logic       lcd_cs2_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_db_o,
  output logic       lcd_db_oe_o,
  input  logic [7:0] lcd_db_i
);

  localparam int C_ASU = imax(1, cdiv(T_ASU_NS, CLK_PERIOD_NS));
  localparam int C_EH  = imax(imax(cdiv(T_EH_NS, CLK_PERIOD_NS),
                                   cdiv(T_RDV_NS, CLK_PERIOD_NS) + 1),
                              imax(1, cdiv(T_DSU_NS, CLK_PERIOD_NS) - C_ASU));
  localparam int C_AH  = imax(1, imax(cdiv(T_AH_NS, CLK_PERIOD_NS),
                                      cdiv(T_DH_NS, CLK_PERIOD_NS)));
  localparam int C_GAP = imax(1, imax(cdiv(T_EL_NS, CLK_PERIOD_NS) - C_AH - C_ASU,
                                      cdiv(T_CYCLE_NS, CLK_PERIOD_NS) - C_ASU - C_EH - C_AH));

  logic       bus_start, bus_half, bus_rs, bus_rw, bus_done;
  logic [7:0] bus_wdata, bus_rdata;
  logic       g_clear, g_step, g_expire;

  lcd_seq_ctrl i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_ready_o    (cmd_ready_o),
    .cmd_op_i       (cmd_op_i),
    .cmd_half_i     (cmd_half_i),
    .cmd_data_i     (cmd_data_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_data_o     (rsp_data_o),
    .err_o          (err_o),
    .bus_start_o    (bus_start),
    .bus_half_o     (bus_half),
    .bus_rs_o       (bus_rs),
    .bus_rw_o       (bus_rw),
    .bus_wdata_o    (bus_wdata),
    .bus_done_i     (bus_done),
    .bus_rdata_i    (bus_rdata),
    .guard_clear_o  (g_clear),
    .guard_step_o   (g_step),
    .guard_expire_i (g_expire)
  );

  lcd_poll_guard #(.LIMIT(POLL_LIMIT)) i_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (g_clear),
    .step_i   (g_step),
    .expire_o (g_expire)
  );

  lcd_bus_cycle #(
    .N_ASU (C_ASU),
    .N_EH  (C_EH),
    .N_AH  (C_AH),
    .N_GAP (C_GAP)
  ) i_cycle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bus_start),
    .half_i  (bus_half),
    .rs_i    (bus_rs),
    .rw_i    (bus_rw),
    .wdata_i (bus_wdata),
    .done_o  (bus_done),
    .rdata_o (bus_rdata),
    .cs1_o   (lcd_cs1_o),
    .cs2_o   (lcd_cs2_o),
    .rs_o    (lcd_rs_o),
    .rw_o    (lcd_rw_o),
    .e_o     (lcd_e_o),
    .db_o    (lcd_db_o),
    .db_oe_o (lcd_db_oe_o),
    .db_i    (lcd_db_i)
  );

endmodule

// File: tb/test_lcd_bus_seq.sv
module test_lcd_bus_seq;

  localparam int TCK      = 4;
  localparam int MIN_EH   = (450 + TCK - 1) / TCK;
  localparam int MIN_EL   = (450 + TCK - 1) / TCK;
  localparam int MIN_PER  = (1000 + TCK - 1) / TCK;
  localparam int MIN_ASU  = (140 + TCK - 1) / TCK;
  localparam int MIN_AH   = (10 + TCK - 1) / TCK;
  localparam int MIN_DSU  = (200 + TCK - 1) / TCK;
  localparam int RDV_CYC  = (320 + TCK - 1) / TCK + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_half = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       rsp_valid, err;
  logic [7:0] rsp_data;
  logic       cs1, cs2, rs, rw, e, oe;
  logic [7:0] db_o;
  logic [7:0] db_i = 8'hA5;

  always #(TCK/2) clk = ~clk;

  lcd_bus_seq i_lcd_bus_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_half_i(cmd_half), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .err_o(err),
    .lcd_cs1_o(cs1), .lcd_cs2_o(cs2), .lcd_rs_o(rs), .lcd_rw_o(rw),
    .lcd_e_o(e), .lcd_db_o(db_o), .lcd_db_oe_o(oe), .lcd_db_i(db_i)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic half; logic rs; logic [7:0] d; } wr_t;
  wr_t        exp_wr[$];
  logic [7:0] exp_rd[$];

  // display model state
  logic [7:0] ram [2][8][64];
  int  ycol[2], pg[2], busy_left[2], rst_left[2], polls[2];
  logic [7:0] olat[2];
  bit  ok_stat[2];
  int  busy_after_wr = 2;
  int  err_cnt = 0, rsp_cnt = 0, rd_bus_cnt = 0;

  // bus monitor state
  logic       prev_e = 1'b0, prev_oe = 1'b0;
  logic [3:0] prev_addr = 4'h0;
  logic [7:0] prev_db = 8'h00;
  int cyc = 0, addr_cnt = 0, dat_cnt = 0, fall_ago = 1000, ehi = 0;
  int last_rise = -100000, last_fall = -100000;

  initial begin
    for (int h = 0; h < 2; h++) begin
      ycol[h] = 0; pg[h] = 0; busy_left[h] = 0; rst_left[h] = 0; polls[h] = 0;
      olat[h] = 8'hEE; ok_stat[h] = 1'b0;
      for (int p = 0; p < 8; p++)
        for (int c = 0; c < 64; c++) ram[h][p][c] = 8'h00;
    end
    rst_left[0] = 3;
  end

  always @(negedge clk) begin
    int   sel;
    bit   rise, fall;
    logic [3:0] addr;
    logic [7:0] st;
    cyc++;
    rise = e && !prev_e;
    fall = !e && prev_e;
    addr = {cs1, cs2, rs, rw};
    sel  = (cs1 && !cs2) ? 0 : ((!cs1 && cs2) ? 1 : -1);

    if (fall) fall_ago = 0; else if (fall_ago < 1000) fall_ago++;
    if (addr != prev_addr) begin
      if (!e) chk(fall_ago >= MIN_AH, "R4 hold after E fall", fall_ago, MIN_AH);
      else    chk(1'b0, "R4 address changed while E high", addr, prev_addr);
      addr_cnt = 0;
    end else addr_cnt++;
    if (prev_oe && (!oe || db_o != prev_db))
      chk(!e && fall_ago >= MIN_AH, "R5 write data hold", fall_ago, MIN_AH);
    if (!oe || db_o != prev_db) dat_cnt = 0; else dat_cnt++;

    if (rise) begin
      chk(addr_cnt >= MIN_ASU, "R4 setup before E rise", addr_cnt, MIN_ASU);
      chk(cs1 ^ cs2, "R2 one select during E", {cs1, cs2}, 2'b01);
      chk(cyc - last_rise >= MIN_PER, "R3 E period", cyc - last_rise, MIN_PER);
      chk(cyc - last_fall >= MIN_EL, "R3 E low", cyc - last_fall, MIN_EL);
      last_rise = cyc;
      ehi = 0;
    end
    if (e) ehi++;
    if (e && rw) chk(!oe, "R6 output enable off during read", oe, 0);

    if (fall) begin
      chk(cyc - last_rise >= MIN_EH, "R3 E high width", cyc - last_rise, MIN_EH);
      last_fall = cyc;
      if (sel >= 0) begin
        if (!prev_addr[0]) begin
          wr_t w;
          chk(dat_cnt >= MIN_DSU && oe, "R5 write data setup", dat_cnt, MIN_DSU);
          chk(ok_stat[sel], "R7 write without ready status", 0, 1);
          ok_stat[sel] = 1'b0;
          if (exp_wr.size() == 0) chk(1'b0, "R9 unexpected write", {rs, db_o}, 0);
          else begin
            w = exp_wr.pop_front();
            chk(w == {sel[0], rs, db_o}, "R2 write scoreboard", {sel[0], rs, db_o}, w);
          end
          if (!rs) begin
            if (db_o[7:6] == 2'b01)    ycol[sel] = int'(db_o[5:0]);
            if (db_o[7:3] == 5'b10111) pg[sel] = int'(db_o[2:0]);
          end else begin
            ram[sel][pg[sel]][ycol[sel]] = db_o;
            ycol[sel] = (ycol[sel] + 1) % 64;
          end
          busy_left[sel] = busy_after_wr;
        end else if (!rs) begin
          polls[sel]++;
          ok_stat[sel] = (busy_left[sel] == 0) && (rst_left[sel] == 0);
          if (busy_left[sel] > 0) busy_left[sel]--;
          if (rst_left[sel] > 0)  rst_left[sel]--;
        end else begin
          chk(ok_stat[sel], "R7 read without ready status", 0, 1);
          ok_stat[sel] = 1'b0;
          rd_bus_cnt++;
          olat[sel] = ram[sel][pg[sel]][ycol[sel]];
          ycol[sel] = (ycol[sel] + 1) % 64;
        end
      end
    end

    // bus value presented to the design, junk until the access time passes
    if (e && rw && sel >= 0 && ehi >= RDV_CYC) begin
      st = {busy_left[sel] > 0, 1'b0, 1'b0, rst_left[sel] > 0, 4'h0};
      db_i <= rs ? olat[sel] : st;
    end else db_i <= 8'hA5;

    if (rsp_valid) begin
      rsp_cnt++;
      if (exp_rd.size() == 0) chk(1'b0, "R10 response without read", rsp_data, 0);
      else begin
        logic [7:0] x;
        x = exp_rd.pop_front();
        chk(rsp_data == x, "R8 read scoreboard", rsp_data, x);
      end
    end
    if (err) err_cnt++;

    prev_e = e; prev_oe = oe; prev_addr = addr; prev_db = db_o;
  end

  task automatic send(input logic [1:0] op, input logic half, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_half = half; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R10 ready drops after accept", cmd_ready, 0);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!cmd_ready);
  endtask

  task automatic wr(input logic half, input logic is_data, input logic [7:0] d);
    int r0;
    r0 = rsp_cnt;
    exp_wr.push_back({half, is_data, d});
    send(is_data ? 2'd1 : 2'd0, half, d);
    wait_idle();
    chk(rsp_cnt == r0, "R10 no response for write", rsp_cnt, r0);
  endtask

  task automatic rd(input logic half, input logic [7:0] x);
    int b0;
    b0 = rd_bus_cnt;
    exp_rd.push_back(x);
    send(2'd2, half, 8'h00);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(rd_bus_cnt - b0 == 2, "R8 two data reads per command", rd_bus_cnt - b0, 2);
  endtask

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    chk(!e && !oe && !cs1 && !cs2 && cmd_ready && !rsp_valid && !err,
        "R1 outputs in reset", {e, oe, cs1, cs2, cmd_ready}, 5'b00001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!e && !oe && cmd_ready && !err, "R1 idle after reset", {e, oe, cmd_ready}, 3'b001);

    // R7: left half reports reset for three polls
    wr(1'b0, 1'b0, 8'hBA);
    chk(polls[0] == 4, "R7 polls while in reset", polls[0], 4);
    p0 = polls[0];
    wr(1'b0, 1'b0, 8'h45);
    chk(polls[0] - p0 == 3, "R7 polls while busy", polls[0] - p0, 3);
    wr(1'b0, 1'b1, 8'hAA);
    wr(1'b0, 1'b1, 8'h55);
    wr(1'b0, 1'b1, 8'h3C);
    // R2: right half, column wraps
    wr(1'b1, 1'b0, 8'hB8);
    wr(1'b1, 1'b0, 8'h7F);
    wr(1'b1, 1'b1, 8'h81);
    wr(1'b1, 1'b1, 8'h7E);
    chk(ram[1][0][0] == 8'h7E, "R2 right half column wrap", ram[1][0][0], 8'h7E);
    chk(ram[0][2][5] == 8'hAA, "R2 left half write", ram[0][2][5], 8'hAA);

    // R8: reads with discarded first access
    wr(1'b0, 1'b0, 8'h45);
    rd(1'b0, 8'hAA);
    rd(1'b0, 8'h3C);
    wr(1'b1, 1'b0, 8'h7F);
    rd(1'b1, 8'h81);

    // R9: right half stuck busy
    busy_left[1] = 300;
    p0 = polls[1];
    send(2'd1, 1'b1, 8'h99);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(err_cnt == 1, "R9 error pulse count", err_cnt, 1);
    chk(polls[1] - p0 == 257, "R9 status reads before abort", polls[1] - p0, 257);
    chk(cmd_ready, "R9 idle after abort", cmd_ready, 1);
    busy_left[1] = 0;
    wr(1'b1, 1'b1, 8'h42);

    repeat (20) @(negedge clk);
    chk(exp_wr.size() == 0, "R2 all writes seen", exp_wr.size(), 0);
    chk(exp_rd.size() == 0, "R10 all reads answered", exp_rd.size(), 0);
    chk(rsp_cnt == 3, "R10 response count", rsp_cnt, 3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule